// File: doc/BRIEF.md
# Manchester Nibble Transmit Serializer

This block is the 10 Mb/s transmit datapath between a MAC's media-independent transmit interface and the line side of an Ethernet physical layer. It runs from a 100 MHz reference clock and divides it by five into a 20 MHz half-bit strobe. From that strobe it makes the 2.5 MHz transmit clock that it gives to the MAC. On each rising edge of that transmit clock it samples the transmit enable and the 4-bit data nibble. Each accepted nibble is sent as four Manchester-encoded bits, with no other line coding. Each half-bit lasts one strobe period.

The output is one line bit plus a flag that is high while encoded data is on the line. When transmit enable is seen low at a transmit clock edge, the nibble in progress finishes and the line goes idle (low). When the 10 Mb/s mode input is low, the block does nothing. The divider is held, the transmit clock stays low, the line is idle, and transmit enable is ignored.

Top module: `man_tx_serializer`

## Requirements
- R1: While reset is asserted, and at the first sample after reset, `tx_clk`, `line_out` and `line_active` are all 0.
- R2: With `mode_10m` high, the half-bit strobe occurs once every DIV (default 5) reference clocks. `tx_clk` has a period of 8·DIV reference clocks and is high for the first 4·DIV of them.
- R3: `tx_en` and `txd` are sampled only in the reference cycle where `tx_clk` rises. A nibble is accepted only if `tx_en` is 1 at that edge. A nibble presented with `tx_en` at 0 produces no line activity.
- R4: An accepted nibble is sent least significant bit first (`txd[0]` first, `txd[3]` last). Each bit occupies two consecutive half-bits.
- R5: A data 1 is sent as a low half-bit followed by a high half-bit. A data 0 is sent as high followed by low. So `line_out` always changes in the middle of a bit.
- R6: The first half-bit of an accepted nibble is on `line_out`, with `line_active` high, in the same reference cycle in which `tx_clk` rises. This is far below the 200 ns limit.
- R7: If `tx_en` is 0 at a `tx_clk` rising edge that follows a frame, the last nibble is sent in full. From that edge on, `line_active` is 0 and `line_out` is 0.
- R8: One reference clock after `mode_10m` is sampled low, `line_active`, `line_out` and `tx_clk` are 0. They stay 0, whatever `tx_en` and `txd` do, until the mode returns.
- R9: Nibbles accepted at consecutive `tx_clk` edges are sent back to back. `line_active` does not drop between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_10m | input | 1 | High when the link runs at 10 Mb/s. Low disables the transmit path |
| tx_en | input | 1 | Transmit enable from the MAC, sampled at `tx_clk` rise |
| txd | input | 4 | Transmit nibble from the MAC, sampled at `tx_clk` rise |
| tx_clk | output | 1 | 2.5 MHz transmit clock presented to the MAC |
| line_out | output | 1 | Manchester-encoded line bit, low when idle |
| line_active | output | 1 | High while an accepted nibble is being sent |

## Verification
The bench looks at bit order within a nibble. A design that shifted out `txd[3]` first, or swapped the half-bit polarity, would produce a half-bit sequence that disagrees with the scoreboard from the first nibble. Frame end is checked at the exact `tx_clk` edge where enable is seen low. A design that cut the last nibble short, or kept transmitting stale data, would either leave scoreboard entries unconsumed or show activity after that edge. The mode input is dropped in the middle of a nibble while enable stays high. A design that ignored the mode, or gated only the data and not the clock, would keep `tx_clk` or the line toggling. The `tx_clk` period and duty cycle are timed so that a divider off by one shows up as a wrong edge spacing.

// File: rtl/man_tx_serializer.sv
module man_tx_serializer #(
  parameter int DIV = 5,
  parameter int NIB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_10m,
  input  logic           tx_en,
  input  logic [NIB-1:0] txd,
  output logic           tx_clk,
  output logic           line_out,
  output logic           line_active
);
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int HBW = $clog2(2 * NIB);

  logic [CW-1:0]  cnt;
  logic [HBW-1:0] hb;
  logic [NIB-1:0] sh;
  logic           act;
  logic           strobe;
  logic           cur_bit;

  assign strobe = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !mode_10m) begin
      cnt <= '0;
      hb  <= '1;
      sh  <= '0;
      act <= 1'b0;
    end else begin
      cnt <= strobe ? '0 : cnt + CW'(1);
      if (strobe) begin
        hb <= hb + HBW'(1);
        if (&hb) begin
          sh  <= txd;
          act <= tx_en;
        end
      end
    end
  end

  assign cur_bit     = sh[hb[HBW-1:1]];
  assign line_out    = act & (hb[0] ? cur_bit : ~cur_bit);
  assign line_active = act;
  assign tx_clk      = ~hb[HBW-1];

  // R2: half-bit phase only advances on the divided strobe
  a_r2_div: assert property (@(posedge clk) disable iff (!rst_n || !mode_10m)
    (hb != $past(hb)) |-> ($past(cnt) == CW'(DIV - 1)));

  // R5: every bit has a mid-bit transition
  a_r5_midbit: assert property (@(posedge clk) disable iff (!rst_n || !mode_10m)
    (line_active && strobe && !hb[0]) |=> (line_out != $past(line_out)));

  // R6: transmission starts on a transmit clock rising edge
  a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_active) |-> $rose(tx_clk));

  // R7: transmission ends only at a nibble boundary unless mode dropped
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(line_active) && $past(mode_10m)) |-> $rose(tx_clk));

  // R8: disabled mode silences clock and line
  a_r8_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_10m |=> (!line_active && !tx_clk && !line_out));
endmodule

// File: tb/man_tx_serializer_bench.sv
module man_tx_serializer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_10m = 1'b1;
  logic tx_en = 1'b0;
  logic [3:0] txd = 4'h0;
  logic tx_clk, line_out, line_active;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic exp_q[$];

  always #2 clk = ~clk;

  man_tx_serializer u_man_tx_serializer (
    .clk(clk), .rst_n(rst_n), .mode_10m(mode_10m), .tx_en(tx_en), .txd(txd),
    .tx_clk(tx_clk), .line_out(line_out), .line_active(line_active));

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic push_nib(input logic [3:0] n);
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back(!n[i]);
      exp_q.push_back(n[i]);
    end
  endtask

  // monitor: five reference clocks per half-bit (R2); compares one half-bit per entry (R4, R5)
  initial begin
    int k = 0;
    logic e = 1'b0;
    bit bad = 0;
    forever begin
      @(negedge clk);
      if (!line_active || !rst_n || !mode_10m) begin
        k = 0;
      end else begin
        if (k == 0) begin
          bad = 0;
          if (exp_q.size() == 0) begin
            chk(0, "R7", 1, 0);
            e = 1'b0;
          end else e = exp_q.pop_front();
        end
        if (line_out !== e) bad = 1;
        k++;
        if (k == 5) begin
          chk(!bad, "R4/R5 half-bit", line_out, e);
          k = 0;
        end
      end
    end
  end

  task automatic send_frame(input int len, input int seed);
    logic [3:0] prev = 4'h0;
    for (int i = 0; i < len; i++) begin
      logic [3:0] n = 4'((seed + i * 7) ^ (i << 1));
      @(posedge tx_clk); #1;
      if (i > 0) begin
        chk(line_active === 1'b1, "R9 back-to-back", line_active, 1);
        chk(line_out === !prev[0], "R6 first half-bit", line_out, !prev[0]);
      end
      txd = n; tx_en = 1'b1; push_nib(n); prev = n;
    end
    @(posedge tx_clk); #1;
    chk(line_active === 1'b1, "R6 start", line_active, 1);
    chk(line_out === !prev[0], "R6 first half-bit", line_out, !prev[0]);
    tx_en = 1'b0; txd = 4'hA;
    @(posedge tx_clk); #1;
    chk(line_active === 1'b0, "R7 idle flag", line_active, 0);
    chk(line_out === 1'b0, "R7 idle line", line_out, 0);
    chk(exp_q.size() == 0, "R7 last nibble complete", exp_q.size(), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    realtime t0, t1, t2;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tx_clk === 1'b0, "R1 tx_clk", tx_clk, 0);
    chk(line_out === 1'b0, "R1 line_out", line_out, 0);
    chk(line_active === 1'b0, "R1 line_active", line_active, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(tx_clk === 1'b0 && line_active === 1'b0, "R1 after reset", tx_clk, 0);

    // R2: tx_clk period 40 reference clocks, high for 20
    @(posedge tx_clk); t0 = $realtime;
    @(negedge tx_clk); t1 = $realtime;
    @(posedge tx_clk); t2 = $realtime;
    chk((t2 - t0) == 160.0, "R2 period", int'(t2 - t0), 160);
    chk((t1 - t0) == 80.0, "R2 high time", int'(t1 - t0), 80);

    // R3: nibbles with enable low do nothing
    txd = 4'hF; tx_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge tx_clk); #1;
      txd = 4'(i + 5);
      repeat (10) @(posedge clk);
      chk(line_active === 1'b0 && line_out === 1'b0, "R3 enable low ignored", line_active, 0);
    end

    send_frame(1, 1);
    send_frame(6, 3);
    send_frame(4, 15);
    send_frame(8, 0);
    send_frame(5, 9);

    // R8: drop mode mid-nibble with enable still high
    @(posedge tx_clk); #1;
    txd = 4'h5; tx_en = 1'b1; push_nib(4'h5);
    @(posedge tx_clk); #1;
    txd = 4'h3; push_nib(4'h3);
    repeat (12) @(posedge clk);
    #1 mode_10m = 1'b0;
    @(posedge clk); #1;
    chk(line_active === 1'b0, "R8 flag off", line_active, 0);
    chk(tx_clk === 1'b0, "R8 clock off", tx_clk, 0);
    chk(line_out === 1'b0, "R8 line off", line_out, 0);
    exp_q.delete();
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      txd = 4'(i);
      if (line_active !== 1'b0 || tx_clk !== 1'b0 || line_out !== 1'b0)
        chk(0, "R8 stays off", line_active, 0);
    end
    chk(tx_clk === 1'b0 && line_active === 1'b0, "R8 held", tx_clk, 0);
    tx_en = 1'b0;
    #1 mode_10m = 1'b1;

    send_frame(3, 12);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule